// File: doc/BRIEF.md
# Translation Table Update Engine

This block owns a small translation table of 64-bit entries and serves host commands that change or inspect it. Each entry holds a translated page base in its upper bits and a two-bit access permission in bits [1:0]. A command carries a table identifier, an I/O bus address, a value or list address, and a page count. The block converts the I/O address to a table index through a configurable window: it subtracts the bus offset and shifts right by the page shift. It then checks the request and performs the work one entry per step. It returns a one-bit status and, for reads, the entry.

Four operations exist. PUT writes one entry and GET reads one. FILL writes one value into a run of consecutive entries. LIST writes a run of entries whose values come from a list in system memory, fetched one 64-bit word at a time through a request/acknowledge read port. Every entry written produces a one-cycle change notification, so that a downstream translation cache can drop or refresh its copy.

Top module: `xlat_table_updater`

## Requirements
- R1: After reset `busy` and `doneValid` are low, and every entry within the configured count reads back as zero with status 0.
- R2: A command whose table identifier has any of bits [63:32] set, or whose bits [31:0] differ from `cfgTableId`, completes with status 1 and writes nothing.
- R3: The I/O address is aligned down to a page boundary, and the index is (aligned address − `cfgBusOffset`) >> `cfgPageShift`. Opcode 0 (PUT) stores `cmdValue` at that index and opcode 1 (GET) returns the stored entry on `doneData`, each with status 0.
- R4: An index at or beyond `cfgEntryCount` completes with status 1 and writes nothing. An address below the bus offset wraps to a huge index and fails the same way.
- R5: Each entry write raises `noteValid` for one cycle. `noteIova` is the page-aligned offset into the window, `noteTarget` is the entry value with the in-page bits cleared, `noteMask` has exactly the in-page bits set, and `notePerm` is entry bits [1:0] (0 none, 1 read-only, 2 write-only, 3 read-write).
- R6: Opcode 2 (FILL) writes `cmdValue` to `cmdCount` entries, stepping one page each. A count above `cfgEntryCount` is rejected with status 1 before any write. A count of zero returns status 0 with no write.
- R7: A FILL or LIST stops at the first entry whose index fails the bound and returns status 1. Entries written before that point keep their new values.
- R8: Opcode 3 (LIST) is rejected with status 1, before any memory read or write, when the count is zero, the count exceeds 512, or the list address has any of bits [11:0] set.
- R9: LIST entry k is read at list address + 8·k. On `memData`, the byte at address memAddr+j sits in bits [8j+7:8j], and the word is taken as big-endian, so the byte at the lowest address becomes entry bits [63:56].
- R10: A command is accepted when `cmdValid` is high and `busy` is low. `busy` is high from the cycle after acceptance through the cycle in which `doneValid` pulses. A command offered while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTableId | input | 32 | Identifier this table answers to |
| cfgBusOffset | input | 64 | Bus address of window index 0 |
| cfgPageShift | input | 6 | log2 of the page size |
| cfgEntryCount | input | IDX_W+1 | Number of valid entries (at most MAX_ENTRIES) |
| cmdValid | input | 1 | Command offered |
| cmdOp | input | 2 | 0 PUT, 1 GET, 2 FILL, 3 LIST |
| cmdTableId | input | 64 | Requested table identifier |
| cmdIoAddr | input | 64 | I/O bus address of the first entry |
| cmdValue | input | 64 | Entry value (PUT, FILL) or list address (LIST) |
| cmdCount | input | CNT_W | Page count (FILL, LIST) |
| busy | output | 1 | Command in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| doneStatus | output | 1 | 0 success, 1 parameter error |
| doneData | output | 64 | Entry read by GET, else zero |
| memReq | output | 1 | List word read request, held until acknowledged |
| memAddr | output | 64 | Byte address of the list word |
| memAck | input | 1 | Read data valid |
| memData | input | 64 | Read data, byte j of the word in lane j |
| noteValid | output | 1 | Entry written this cycle |
| noteIova | output | 64 | Page-aligned window offset of the written entry |
| noteTarget | output | 64 | Translated page base |
| noteMask | output | 64 | In-page address mask |
| notePerm | output | 2 | Decoded permission |

## Verification
The bench builds the block with MAX_ENTRIES of 16 and runs two configurations: a 4 KiB page with zero offset and all 16 entries in use, and a 64 KiB page with a nonzero bus offset and only 10 entries enabled. With so few entries, every index can be written, notified and read back in each configuration. Runs that stop partway through, the exact-count and count-plus-one fill limits, and a 512-word list that hits the end of the table all fit in a few thousand cycles. The nonzero offset makes an address below the window reachable, and the 10-entry case keeps the enabled count apart from the storage depth.

// File: rtl/xlat_upd_pkg.sv
package xlat_upd_pkg;

  typedef enum logic [1:0] {
    OP_PUT  = 2'd0,
    OP_GET  = 2'd1,
    OP_FILL = 2'd2,
    OP_LIST = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_RD   = 2'd1,
    PERM_WR   = 2'd2,
    PERM_RW   = 2'd3
  } perm_e;

  // control -> datapath
  typedef struct packed {
    logic load;     // capture the command
    logic fetch;    // capture a list word
    logic write;    // store current value at current index
    logic read;     // capture entry at current index
    logic advance;  // next page, next entry
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic idOk;
    logic limitOk;
    logic zeroCnt;
    logic idxOk;
    logic lastOne;
  } flags_t;

  localparam logic STAT_OK    = 1'b0;
  localparam logic STAT_PARAM = 1'b1;

  function automatic logic [63:0] swapBytes(input logic [63:0] w);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) begin
      r[8*b +: 8] = w[8*(7-b) +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/xlat_upd_table.sv
module xlat_upd_table #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [WIDTH-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slot[g] <= '0;
      end else if (wrEn && (wrIdx == IDX_W'(g))) begin
        slot[g] <= wrData;
      end
    end
  end

  assign rdData = slot[rdIdx];

endmodule

// File: rtl/xlat_upd_dpath.sv
module xlat_upd_dpath
  import xlat_upd_pkg::*;
#(
  parameter int MAX_ENTRIES = 16,
  parameter int CNT_W       = 16,
  parameter int SHIFT_W     = 6,
  parameter int MAX_LIST    = 512,
  parameter int LIST_ALIGN  = 12,
  localparam int IDX_W  = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int ECNT_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        cmdOp,
  input  logic [63:0]       cmdTableId,
  input  logic [63:0]       cmdIoAddr,
  input  logic [63:0]       cmdValue,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [31:0]       cfgTableId,
  input  logic [63:0]       cfgBusOffset,
  input  logic [SHIFT_W-1:0] cfgPageShift,
  input  logic [ECNT_W-1:0] cfgEntryCount,
  input  logic [63:0]       memData,
  output op_e               opCur,
  output flags_t            flags,
  output logic [63:0]       memAddr,
  output logic [63:0]       rdData,
  output logic [63:0]       noteIova,
  output logic [63:0]       noteTarget,
  output logic [63:0]       noteMask,
  output logic [1:0]        notePerm
);

  logic [63:0]      tidR, ioR, valR, curVal, rdR;
  logic [CNT_W-1:0] cntR, doneCnt, doneCntNext;
  op_e              opR;

  logic [63:0] pageSize, pageMask, winOffs, idxFull, tblRd;
  logic [IDX_W-1:0] idx;

  assign pageSize = 64'd1 << cfgPageShift;
  assign pageMask = ~(pageSize - 64'd1);
  assign winOffs  = ioR - cfgBusOffset;
  assign idxFull  = winOffs >> cfgPageShift;
  assign idx      = idxFull[IDX_W-1:0];
  assign doneCntNext = doneCnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR     <= OP_PUT;
      tidR    <= '0;
      ioR     <= '0;
      valR    <= '0;
      cntR    <= '0;
      doneCnt <= '0;
      curVal  <= '0;
      rdR     <= '0;
    end else begin
      if (strb.load) begin
        opR     <= op_e'(cmdOp);
        tidR    <= cmdTableId;
        ioR     <= cmdIoAddr & pageMask;
        valR    <= cmdValue;
        cntR    <= cmdCount;
        doneCnt <= '0;
        curVal  <= cmdValue;
        rdR     <= '0;
      end
      if (strb.fetch) begin
        curVal <= swapBytes(memData);
      end
      if (strb.read) begin
        rdR <= tblRd;
      end
      if (strb.advance) begin
        doneCnt <= doneCntNext;
        ioR     <= ioR + pageSize;
      end
    end
  end

  xlat_upd_table #(
    .DEPTH (MAX_ENTRIES),
    .WIDTH (64)
  ) u_table (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (strb.write),
    .wrIdx  (idx),
    .wrData (curVal),
    .rdIdx  (idx),
    .rdData (tblRd)
  );

  always_comb begin
    flags.idOk    = (tidR[63:32] == 32'd0) && (tidR[31:0] == cfgTableId);
    flags.zeroCnt = (cntR == '0);
    flags.idxOk   = (idxFull < 64'(cfgEntryCount)) && (idxFull < 64'(MAX_ENTRIES));
    flags.lastOne = (doneCntNext == cntR);
    unique case (opR)
      OP_LIST: flags.limitOk = (cntR != '0) &&
                               (32'(cntR) <= 32'(MAX_LIST)) &&
                               (valR[LIST_ALIGN-1:0] == '0);
      OP_FILL: flags.limitOk = (32'(cntR) <= 32'(cfgEntryCount));
      default: flags.limitOk = 1'b1;
    endcase
  end

  assign opCur      = opR;
  assign memAddr    = valR + (64'(doneCnt) << 3);
  assign rdData     = rdR;
  assign noteIova   = winOffs & pageMask;
  assign noteTarget = curVal & pageMask;
  assign noteMask   = ~pageMask;
  assign notePerm   = curVal[1:0];

endmodule

// File: rtl/xlat_upd_ctrl.sv
module xlat_upd_ctrl
  import xlat_upd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdValid,
  input  op_e     opCur,
  input  flags_t  flags,
  input  logic    memAck,
  output strobe_t strb,
  output logic    busy,
  output logic    doneValid,
  output logic    doneStatus,
  output logic    memReq
);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_FETCH, S_STEP, S_DONE
  } state_e;

  state_e state, stateNext;
  logic   statR, statNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      statR <= STAT_OK;
    end else begin
      state <= stateNext;
      statR <= statNext;
    end
  end

  always_comb begin
    stateNext = state;
    statNext  = statR;
    strb      = '0;
    memReq    = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (cmdValid) begin
          strb.load = 1'b1;
          stateNext = S_CHECK;
        end
      end
      S_CHECK: begin
        if (!flags.idOk || !flags.limitOk) begin
          statNext  = STAT_PARAM;
          stateNext = S_DONE;
        end else if (opCur == OP_FILL && flags.zeroCnt) begin
          statNext  = STAT_OK;
          stateNext = S_DONE;
        end else if (opCur == OP_LIST) begin
          stateNext = S_FETCH;
        end else begin
          stateNext = S_STEP;
        end
      end
      S_FETCH: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.fetch = 1'b1;
          stateNext  = S_STEP;
        end
      end
      S_STEP: begin
        if (!flags.idxOk) begin
          statNext  = STAT_PARAM;
          stateNext = S_DONE;
        end else if (opCur == OP_GET) begin
          strb.read = 1'b1;
          statNext  = STAT_OK;
          stateNext = S_DONE;
        end else if (opCur == OP_PUT) begin
          strb.write = 1'b1;
          statNext   = STAT_OK;
          stateNext  = S_DONE;
        end else begin
          strb.write   = 1'b1;
          strb.advance = 1'b1;
          if (flags.lastOne) begin
            statNext  = STAT_OK;
            stateNext = S_DONE;
          end else if (opCur == OP_LIST) begin
            stateNext = S_FETCH;
          end else begin
            stateNext = S_STEP;
          end
        end
      end
      S_DONE: begin
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy       = (state != S_IDLE);
  assign doneValid  = (state == S_DONE);
  assign doneStatus = statR;

endmodule

// File: rtl/xlat_table_updater.sv
module xlat_table_updater
  import xlat_upd_pkg::*;
#(
  parameter int MAX_ENTRIES = 16,
  parameter int CNT_W       = 16,
  parameter int SHIFT_W     = 6,
  parameter int MAX_LIST    = 512,
  parameter int LIST_ALIGN  = 12,
  localparam int IDX_W  = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int ECNT_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        cfgTableId,
  input  logic [63:0]        cfgBusOffset,
  input  logic [SHIFT_W-1:0] cfgPageShift,
  input  logic [ECNT_W-1:0]  cfgEntryCount,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [63:0]        cmdTableId,
  input  logic [63:0]        cmdIoAddr,
  input  logic [63:0]        cmdValue,
  input  logic [CNT_W-1:0]   cmdCount,
  output logic               busy,
  output logic               doneValid,
  output logic               doneStatus,
  output logic [63:0]        doneData,
  output logic               memReq,
  output logic [63:0]        memAddr,
  input  logic               memAck,
  input  logic [63:0]        memData,
  output logic               noteValid,
  output logic [63:0]        noteIova,
  output logic [63:0]        noteTarget,
  output logic [63:0]        noteMask,
  output logic [1:0]         notePerm
);

  strobe_t strb;
  flags_t  flags;
  op_e     opCur;

  xlat_upd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .opCur      (opCur),
    .flags      (flags),
    .memAck     (memAck),
    .strb       (strb),
    .busy       (busy),
    .doneValid  (doneValid),
    .doneStatus (doneStatus),
    .memReq     (memReq)
  );

  xlat_upd_dpath #(
    .MAX_ENTRIES (MAX_ENTRIES),
    .CNT_W       (CNT_W),
    .SHIFT_W     (SHIFT_W),
    .MAX_LIST    (MAX_LIST),
    .LIST_ALIGN  (LIST_ALIGN)
  ) u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .cmdOp         (cmdOp),
    .cmdTableId    (cmdTableId),
    .cmdIoAddr     (cmdIoAddr),
    .cmdValue      (cmdValue),
    .cmdCount      (cmdCount),
    .cfgTableId    (cfgTableId),
    .cfgBusOffset  (cfgBusOffset),
    .cfgPageShift  (cfgPageShift),
    .cfgEntryCount (cfgEntryCount),
    .memData       (memData),
    .opCur         (opCur),
    .flags         (flags),
    .memAddr       (memAddr),
    .rdData        (doneData),
    .noteIova      (noteIova),
    .noteTarget    (noteTarget),
    .noteMask      (noteMask),
    .notePerm      (notePerm)
  );

  assign noteValid = strb.write;

endmodule

// File: rtl/xlat_table_updater_chk.sv
module xlat_table_updater_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        busy,
  input logic        doneValid,
  input logic        memReq,
  input logic        memAck,
  input logic [63:0] memAddr,
  input logic        noteValid,
  input logic [63:0] noteIova,
  input logic [63:0] noteTarget,
  input logic [63:0] noteMask
);

  // R10: an offered command is taken when idle
  a_r10_accept: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy);

  // R10: completion happens while busy, and busy then drops
  a_r10_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> busy);
  a_r10_release: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !busy);

  // R5: notifications only inside a command, never with completion
  a_r5_note_busy: assert property (@(posedge clk) disable iff (!rstN)
    noteValid |-> (busy && !doneValid));

  // R5: reported addresses carry no in-page bits
  a_r5_note_aligned: assert property (@(posedge clk) disable iff (!rstN)
    noteValid |-> (((noteIova & noteMask) == 64'd0) && ((noteTarget & noteMask) == 64'd0)));

  // R9: list reads are word aligned and held until acknowledged
  a_r9_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[2:0] == 3'd0));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr)));

  // R8: no memory traffic outside a command
  a_r8_req_busy: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

endmodule

bind xlat_table_updater xlat_table_updater_chk u_chk (.*);

// File: tb/test_xlat_table_updater.sv
`timescale 1ns/1ps
module test_xlat_table_updater;

  localparam int NENT = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgTableId = 32'h0;
  logic [63:0] cfgBusOffset = 64'h0;
  logic [5:0]  cfgPageShift = 6'd12;
  logic [4:0]  cfgEntryCount = 5'd16;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [63:0] cmdTableId = 64'h0, cmdIoAddr = 64'h0, cmdValue = 64'h0;
  logic [15:0] cmdCount = 16'h0;
  logic        busy, doneValid, doneStatus, memReq, noteValid;
  logic [63:0] doneData, memAddr, noteIova, noteTarget, noteMask;
  logic [1:0]  notePerm;
  logic        memAck = 1'b0;
  logic [63:0] memData = 64'h0;

  always #2.5 clk = ~clk;

  xlat_table_updater i_xlat_table_updater (.*);

  int total = 0, bad = 0;
  int noteCnt = 0, fetchCnt = 0;
  logic [63:0] nIova [4096];
  logic [63:0] nTarget [4096];
  logic [63:0] nMask [4096];
  logic [1:0]  nPerm [4096];
  logic [63:0] model [NENT];

  function automatic logic [63:0] listWord(input logic [63:0] a);
    return 64'hC0DE_0000_0000_0000 ^ {a[31:0], ~a[31:0]};
  endfunction

  // list memory: one-cycle acknowledge, byte j of the word in lane j
  always @(negedge clk) begin
    if (memAck) begin
      memAck <= 1'b0;
    end else if (memReq) begin
      logic [63:0] w;
      w = listWord(memAddr);
      for (int j = 0; j < 8; j++) memData[8*j +: 8] <= w[63-8*j -: 8];
      memAck <= 1'b1;
      fetchCnt <= fetchCnt + 1;
    end
  end

  always @(negedge clk) begin
    if (noteValid) begin
      nIova[noteCnt % 4096]   <= noteIova;
      nTarget[noteCnt % 4096] <= noteTarget;
      nMask[noteCnt % 4096]   <= noteMask;
      nPerm[noteCnt % 4096]   <= notePerm;
      noteCnt <= noteCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  int nBase, fBase;
  logic        st;
  logic [63:0] dat;

  task automatic issue(input logic [1:0] op, input logic [63:0] tid, input logic [63:0] io,
                       input logic [63:0] val, input logic [15:0] cnt);
    @(negedge clk);
    nBase = noteCnt; fBase = fetchCnt;
    cmdValid = 1'b1; cmdOp = op; cmdTableId = tid; cmdIoAddr = io;
    cmdValue = val; cmdCount = cnt;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic finish(input string req);
    for (int w = 0; w < 6000 && !doneValid; w++) @(negedge clk);
    chk(doneValid == 1'b1, req, {63'd0, doneValid}, 64'd1);
    st = doneStatus; dat = doneData;
    @(negedge clk);
  endtask

  task automatic runCmd(input logic [1:0] op, input logic [63:0] tid, input logic [63:0] io,
                        input logic [63:0] val, input logic [15:0] cnt, input string req);
    issue(op, tid, io, val, cnt);
    chk(busy == 1'b1, "R10 busy after accept", {63'd0, busy}, 64'd1);
    finish(req);
  endtask

  function automatic logic [63:0] ioOf(input int i, input logic [63:0] junk);
    logic [63:0] p;
    p = 64'd1 << cfgPageShift;
    return cfgBusOffset + 64'(i) * p + (junk & (p - 64'd1));
  endfunction

  task automatic checkTable(input string req);
    for (int i = 0; i < int'(cfgEntryCount); i++) begin
      runCmd(2'd1, {32'd0, cfgTableId}, ioOf(i, 64'h0), 64'h0, 16'd0, req);
      chk(st == 1'b0 && dat == model[i], req, dat, model[i]);
    end
  endtask

  task automatic suite(input logic [31:0] id, input logic [63:0] off, input logic [5:0] sh,
                       input logic [4:0] ec);
    logic [63:0] tid, pg, pm, v;
    int E;
    cfgTableId = id; cfgBusOffset = off; cfgPageShift = sh; cfgEntryCount = ec;
    tid = {32'd0, id}; pg = 64'd1 << sh; pm = ~(pg - 64'd1); E = int'(ec);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(busy == 1'b0 && doneValid == 1'b0, "R1 idle after reset", {62'd0, busy, doneValid}, 64'd0);
    for (int i = 0; i < NENT; i++) model[i] = 64'd0;
    checkTable("R1 cleared entry");

    // R3 / R5: single writes through every index, unaligned addresses
    for (int i = 0; i < E; i++) begin
      v = (64'hBEEF << 32) + (64'(i) << 20) + 64'h100 + 64'(i & 3);
      runCmd(2'd0, tid, ioOf(i, 64'(i) * 64'h733 + 64'h5), v, 16'd9, "R3 put status");
      chk(st == 1'b0, "R3 put status", {63'd0, st}, 64'd0);
      chk(noteCnt - nBase == 1, "R5 one note per put", 64'(noteCnt - nBase), 64'd1);
      chk(nIova[nBase % 4096] == 64'(i) * pg, "R5 note iova", nIova[nBase % 4096], 64'(i) * pg);
      chk(nTarget[nBase % 4096] == (v & pm), "R5 note target", nTarget[nBase % 4096], v & pm);
      chk(nMask[nBase % 4096] == pg - 64'd1, "R5 note mask", nMask[nBase % 4096], pg - 64'd1);
      chk(nPerm[nBase % 4096] == 2'(i & 3), "R5 note perm", 64'(nPerm[nBase % 4096]), 64'(i & 3));
      model[i] = v;
    end
    checkTable("R3 get after put");

    // R4: out of window
    runCmd(2'd0, tid, ioOf(E, 64'h0), 64'h1234_5003, 16'd1, "R4 past end");
    chk(st == 1'b1 && noteCnt == nBase, "R4 past end rejected", {63'd0, st}, 64'd1);
    if (off != 64'd0) begin
      runCmd(2'd0, tid, off - pg, 64'h1234_5003, 16'd1, "R4 below offset");
      chk(st == 1'b1 && noteCnt == nBase, "R4 below offset rejected", {63'd0, st}, 64'd1);
    end

    // R2: identifier checks
    runCmd(2'd0, {32'd0, id ^ 32'h1}, ioOf(0, 64'h0), 64'hAAAA_0003, 16'd1, "R2 wrong id");
    chk(st == 1'b1 && noteCnt == nBase, "R2 wrong id rejected", {63'd0, st}, 64'd1);
    runCmd(2'd0, {32'd1, id}, ioOf(0, 64'h0), 64'hAAAA_0003, 16'd1, "R2 wide id");
    chk(st == 1'b1 && noteCnt == nBase, "R2 wide id rejected", {63'd0, st}, 64'd1);
    runCmd(2'd1, {32'd0, id ^ 32'h8000_0000}, ioOf(0, 64'h0), 64'h0, 16'd0, "R2 get wrong id");
    chk(st == 1'b1 && dat == 64'd0, "R2 get wrong id", dat, 64'd0);
    checkTable("R2 table untouched");

    // R6: fill
    v = 64'h0F0F_0000_0000_0002;
    runCmd(2'd2, tid, ioOf(2, 64'h3), v, 16'd5, "R6 fill run");
    chk(st == 1'b0 && noteCnt - nBase == 5, "R6 fill run", 64'(noteCnt - nBase), 64'd5);
    for (int k = 0; k < 5; k++) begin
      chk(nIova[(nBase + k) % 4096] == 64'(2 + k) * pg, "R6 fill step", nIova[(nBase + k) % 4096], 64'(2 + k) * pg);
      model[2 + k] = v;
    end
    runCmd(2'd2, tid, ioOf(0, 64'h0), 64'h77, 16'(E + 1), "R6 fill too long");
    chk(st == 1'b1 && noteCnt == nBase, "R6 fill too long", {63'd0, st}, 64'd1);
    runCmd(2'd2, tid, ioOf(0, 64'h0), 64'h77, 16'd0, "R6 fill zero");
    chk(st == 1'b0 && noteCnt == nBase, "R6 fill zero", 64'(noteCnt - nBase), 64'd0);
    checkTable("R6 after fill");
    v = 64'h5555_0000_0000_0001;
    runCmd(2'd2, tid, ioOf(0, 64'h0), v, 16'(E), "R6 fill whole table");
    chk(st == 1'b0 && noteCnt - nBase == E, "R6 fill whole table", 64'(noteCnt - nBase), 64'(E));
    for (int i = 0; i < E; i++) model[i] = v;

    // R7: fill running off the end
    v = 64'h6666_0000_0000_0003;
    runCmd(2'd2, tid, ioOf(E - 2, 64'h0), v, 16'd4, "R7 fill abort");
    chk(st == 1'b1 && noteCnt - nBase == 2, "R7 fill abort", 64'(noteCnt - nBase), 64'd2);
    model[E - 2] = v; model[E - 1] = v;
    checkTable("R7 after fill abort");

    // R9: list write
    runCmd(2'd3, tid, ioOf(1, 64'h0), 64'h2_0000, 16'd6, "R9 list");
    chk(st == 1'b0 && fetchCnt - fBase == 6 && noteCnt - nBase == 6, "R9 list", 64'(fetchCnt - fBase), 64'd6);
    for (int k = 0; k < 6; k++) begin
      model[1 + k] = listWord(64'h2_0000 + 64'(8 * k));
      chk(nTarget[(nBase + k) % 4096] == (model[1 + k] & pm), "R9 list note target",
          nTarget[(nBase + k) % 4096], model[1 + k] & pm);
    end
    checkTable("R9 list contents");

    // R8: list limits
    runCmd(2'd3, tid, ioOf(0, 64'h0), 64'h2_0800, 16'd2, "R8 misaligned list");
    chk(st == 1'b1 && fetchCnt == fBase && noteCnt == nBase, "R8 misaligned list", 64'(fetchCnt - fBase), 64'd0);
    runCmd(2'd3, tid, ioOf(0, 64'h0), 64'h2_0000, 16'd513, "R8 list too long");
    chk(st == 1'b1 && fetchCnt == fBase && noteCnt == nBase, "R8 list too long", 64'(fetchCnt - fBase), 64'd0);
    runCmd(2'd3, tid, ioOf(0, 64'h0), 64'h2_0000, 16'd0, "R8 list empty");
    chk(st == 1'b1 && fetchCnt == fBase, "R8 list empty", {63'd0, st}, 64'd1);

    // R7: longest list, stops at end of table
    runCmd(2'd3, tid, ioOf(0, 64'h0), 64'h3_0000, 16'd512, "R7 list abort");
    chk(st == 1'b1 && noteCnt - nBase == E, "R7 list abort notes", 64'(noteCnt - nBase), 64'(E));
    chk(fetchCnt - fBase == E + 1, "R7 list abort fetches", 64'(fetchCnt - fBase), 64'(E + 1));
    for (int i = 0; i < E; i++) model[i] = listWord(64'h3_0000 + 64'(8 * i));
    checkTable("R7 after list abort");

    // R10: command offered while busy is dropped
    issue(2'd3, tid, ioOf(0, 64'h0), 64'h4_0000, 16'd3);
    cmdValid = 1'b1; cmdOp = 2'd0; cmdTableId = tid; cmdIoAddr = ioOf(E - 1, 64'h0);
    cmdValue = 64'hDEAD_0000_0000_0003; cmdCount = 16'd1;
    @(negedge clk);
    cmdValid = 1'b0;
    finish("R10 list during busy");
    chk(st == 1'b0 && noteCnt - nBase == 3, "R10 only list writes", 64'(noteCnt - nBase), 64'd3);
    chk(busy == 1'b0, "R10 busy released", {63'd0, busy}, 64'd0);
    for (int k = 0; k < 3; k++) model[k] = listWord(64'h4_0000 + 64'(8 * k));
    checkTable("R10 ignored put");
  endtask

  initial begin
    suite(32'h0000_1234, 64'h0, 6'd12, 5'd16);
    suite(32'hABCD_0001, 64'h4000_0000, 6'd16, 5'd10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule